// File: doc/BRIEF.md
# Serial Nonvolatile Shadow SRAM Slave

This block models, in synthesizable form, the device side of a small serial memory. It holds sixteen 16-bit words of working RAM, and each word is backed by a nonvolatile copy. A host drives a chip-enable, a serial clock and a serial data line. The host shifts in 8-bit instructions that write or read a RAM word, set or clear a write-enable latch, copy the RAM into the nonvolatile bank (store), or copy the bank back into the RAM (recall). Two active-low pins start a store or a recall from hardware.

The nonvolatile bank is a register bank inside the block. A store or a recall is modelled as a busy period whose length is a parameter given in clock cycles. The copy happens in the last cycle of that period. After reset the block runs a recall by itself before it accepts any instruction. The serial clock is oversampled by the system clock, so all state is in one clock domain. The serial interface has no valid/ready handshake and no back-pressure: the host paces every transfer with the serial clock, and the block has no way to stall it.

Top module: `snv_ram_slave`

## Requirements
- R1: While chip-enable is high and no instruction has begun, 0 bits on the data input are ignored. An instruction starts with the first 1 bit sampled on a rising serial-clock edge, and that 1 counts as the instruction MSB.
- R2: The instruction byte is 1, then address bits [6:3], then opcode bits [2:0], sent MSB first. Opcode 000 clears the write-enable latch, 001 stores, 010 does nothing, 011 writes, 100 sets the write-enable latch, 101 recalls, and 11x reads.
- R3: Chip-enable low aborts any instruction in progress, and do_oe is low in the next cycle. do_oe is high only while read data is being shifted out.
- R4: A write instruction is followed by data bits, MSB first. When chip-enable falls, the shifted word is written to the addressed RAM word, provided the write-enable latch is set.
- R5: If chip-enable falls after fewer than 16 data bits, the bits received so far are written right-aligned, with zeros above them.
- R6: If more than 16 data bits are sent, the last 16 bits received are the ones written.
- R7: For a read, instruction bit 0 is ignored. Data bit 15 appears on do_o after the falling edge of the 8th serial clock. Each later bit, down to bit 0, appears after each following rising edge.
- R8: Opcode 100 sets the write-enable latch and opcode 000 clears it. The latch is cleared by reset and when a store completes. While it is clear, writes leave the RAM unchanged.
- R9: A store starts only if both the write-enable latch and the previous-recall latch are set. The previous-recall latch is set only when an instruction or pin recall completes.
- R10: A falling edge on store_n starts a store, under the same guard as R9. A falling edge on recall_n starts a recall.
- R11: After reset, busy is high for RECALL_CYCLES cycles, and then the RAM holds the bank's initial contents: word a = {a, 4'hC, ~a, 4'h3}. Instructions sent during this period have no effect, and the period does not set the previous-recall latch.
- R12: A store holds busy high for exactly STORE_CYCLES cycles and then copies all RAM words into the bank. While busy is high, instructions are ignored and do_oe stays low.
- R13: A recall holds busy high for exactly RECALL_CYCLES cycles and then copies the whole bank over the RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low power-up reset |
| ce | input | 1 | Chip enable; low ends or aborts an instruction |
| sk | input | 1 | Serial clock from the host |
| di | input | 1 | Serial data in, sampled on sk rising edges |
| store_n | input | 1 | Active-low hardware store request (edge) |
| recall_n | input | 1 | Active-low hardware recall request (edge) |
| do_o | output | 1 | Serial read data |
| do_oe | output | 1 | Output enable for do_o (high-impedance when low) |
| busy | output | 1 | High while a store or recall is running |

## Verification
The bench targets the points where a plausible implementation slips:
- Leading 0 bits before the start bit: a decoder that counts them would misread the address and write the wrong word.
- A write cut short by chip-enable: a design that discards it leaves the old word in place. A design that left-aligns the bits gives a different value.
- A write longer than 16 bits: a design that stops shifting at 16 bits keeps the first bits instead of the last.
- Read timing: if the first bit comes out on a rising edge, the whole word reads back shifted by one bit.
- Store guarding: a store without a prior recall, or one that does not clear the write-enable latch afterwards, shows up either as a busy period or as a write that lands when it should not.
- Exact busy lengths and the copy direction: both are checked by storing, overwriting and recalling a word.

// File: rtl/snv_pkg.sv
package snv_pkg;
  localparam int WORD_W = 16;
  localparam int ADDR_W = 4;
  localparam int WORDS  = 1 << ADDR_W;

  typedef enum logic [2:0] {
    S_IDLE, S_INSTR, S_WRITE, S_READ, S_DONE
  } ser_state_t;

  typedef enum logic [1:0] {
    M_IDLE, M_STORE, M_RECALL
  } nv_mode_t;

  // initial contents of the nonvolatile bank
  function automatic logic [WORD_W-1:0] seed_word(input logic [ADDR_W-1:0] a);
    return {a, 4'hC, ~a, 4'h3};
  endfunction
endpackage

// File: rtl/snv_serial.sv
module snv_serial
  import snv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              sk,
  input  logic              di,
  input  logic              busy,
  input  logic              wel,
  input  logic [WORD_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              wren_p,
  output logic              wrds_p,
  output logic              sto_p,
  output logic              rcl_p,
  output logic              do_o,
  output logic              do_oe
);
  ser_state_t        st;
  logic              sk_q;
  logic [5:0]        ins;
  logic [2:0]        cnt;
  logic [ADDR_W-1:0] addr;
  logic [WORD_W-1:0] dsh;
  logic [WORD_W-1:0] osh;
  logic              dgot;
  logic              rise, fall;

  assign rise    = sk & ~sk_q;
  assign fall    = ~sk & sk_q;
  assign rd_addr = addr;
  assign wr_addr = addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sk_q <= 1'b0;   st <= S_IDLE;  ins <= '0;  cnt <= '0;
      addr <= '0;     dsh <= '0;     osh <= '0;  dgot <= 1'b0;
      do_o <= 1'b0;   do_oe <= 1'b0; wr_en <= 1'b0; wr_data <= '0;
      wren_p <= 1'b0; wrds_p <= 1'b0; sto_p <= 1'b0; rcl_p <= 1'b0;
    end else begin
      sk_q   <= sk;
      wr_en  <= 1'b0;
      wren_p <= 1'b0;
      wrds_p <= 1'b0;
      sto_p  <= 1'b0;
      rcl_p  <= 1'b0;
      if (!ce || busy) begin
        // chip-enable drop commits a pending (possibly partial) write
        if (!ce && !busy && st == S_WRITE && dgot && wel) begin
          wr_en   <= 1'b1;
          wr_data <= dsh;
        end
        st    <= S_IDLE;
        do_oe <= 1'b0;
        dgot  <= 1'b0;
      end else begin
        case (st)
          S_IDLE: if (rise && di) begin
            st  <= S_INSTR;
            ins <= '0;
            cnt <= 3'd1;
          end
          S_INSTR: if (rise) begin
            if (cnt == 3'd7) begin
              addr <= ins[5:2];
              if (ins[1:0] == 2'b11) begin
                st <= S_READ;
              end else begin
                st <= S_DONE;
                case ({ins[1:0], di})
                  3'b011: begin st <= S_WRITE; dsh <= '0; dgot <= 1'b0; end
                  3'b100: wren_p <= 1'b1;
                  3'b000: wrds_p <= 1'b1;
                  3'b001: sto_p  <= 1'b1;
                  3'b101: rcl_p  <= 1'b1;
                  default: ;
                endcase
              end
            end else begin
              ins <= {ins[4:0], di};
              cnt <= cnt + 3'd1;
            end
          end
          S_WRITE: if (rise) begin
            dsh  <= {dsh[WORD_W-2:0], di};
            dgot <= 1'b1;
          end
          S_READ: begin
            if (fall && !do_oe) begin
              do_oe <= 1'b1;
              do_o  <= rd_data[WORD_W-1];
              osh   <= {rd_data[WORD_W-2:0], rd_data[WORD_W-1]};
            end else if (rise && do_oe) begin
              do_o <= osh[WORD_W-1];
              osh  <= {osh[WORD_W-2:0], osh[WORD_W-1]};
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/snv_ctl.sv
module snv_ctl
  import snv_pkg::*;
#(
  parameter int STORE_CYCLES  = 40,
  parameter int RECALL_CYCLES = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sto_p,
  input  logic rcl_p,
  input  logic wren_p,
  input  logic wrds_p,
  input  logic store_n,
  input  logic recall_n,
  output logic busy,
  output logic wel,
  output logic prl,
  output logic copy_to_nv,
  output logic copy_to_ram
);
  localparam int MAXC  = (STORE_CYCLES > RECALL_CYCLES) ? STORE_CYCLES : RECALL_CYCLES;
  localparam int CNT_W = $clog2(MAXC + 1);

  nv_mode_t   mode;
  logic [CNT_W-1:0] cnt;
  logic       pu;
  logic       st_q, rc_q;
  logic       want_store, want_recall, last;

  assign want_store  = (sto_p | (st_q & ~store_n)) & wel & prl;
  assign want_recall = rcl_p | (rc_q & ~recall_n);
  assign last        = (cnt == '0);
  assign busy        = (mode != M_IDLE);
  assign copy_to_nv  = (mode == M_STORE)  && last;
  assign copy_to_ram = (mode == M_RECALL) && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= M_RECALL;
      cnt  <= CNT_W'(RECALL_CYCLES - 1);
      pu   <= 1'b1;
      wel  <= 1'b0;
      prl  <= 1'b0;
      st_q <= 1'b1;
      rc_q <= 1'b1;
    end else begin
      st_q <= store_n;
      rc_q <= recall_n;
      if (mode != M_IDLE) begin
        if (last) begin
          if (mode == M_STORE) wel <= 1'b0;
          else if (!pu)        prl <= 1'b1;
          pu   <= 1'b0;
          mode <= M_IDLE;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else begin
        if (want_store) begin
          mode <= M_STORE;
          cnt  <= CNT_W'(STORE_CYCLES - 1);
        end else if (want_recall) begin
          mode <= M_RECALL;
          cnt  <= CNT_W'(RECALL_CYCLES - 1);
        end
        if (wren_p) wel <= 1'b1;
        if (wrds_p) wel <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/snv_array.sv
module snv_array
  import snv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              copy_to_nv,
  input  logic              copy_to_ram,
  output logic [WORD_W-1:0] rd_data
);
  logic [WORD_W-1:0] ram [WORDS];
  logic [WORD_W-1:0] nv  [WORDS];

  assign rd_data = ram[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) begin
        ram[i] <= '0;
        nv[i]  <= seed_word(ADDR_W'(i));
      end
    end else if (copy_to_ram) begin
      for (int i = 0; i < WORDS; i++) ram[i] <= nv[i];
    end else if (copy_to_nv) begin
      for (int i = 0; i < WORDS; i++) nv[i] <= ram[i];
    end else if (wr_en) begin
      ram[wr_addr] <= wr_data;
    end
  end
endmodule

// File: rtl/snv_ram_slave.sv
module snv_ram_slave
  import snv_pkg::*;
#(
  parameter int STORE_CYCLES  = 40,
  parameter int RECALL_CYCLES = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce,
  input  logic sk,
  input  logic di,
  input  logic store_n,
  input  logic recall_n,
  output logic do_o,
  output logic do_oe,
  output logic busy
);
  logic [WORD_W-1:0] rd_data, wr_data;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic wr_en, wren_p, wrds_p, sto_p, rcl_p;
  logic wel, prl, copy_to_nv, copy_to_ram;

  snv_serial u_ser (
    .clk(clk), .rst_n(rst_n), .ce(ce), .sk(sk), .di(di),
    .busy(busy), .wel(wel), .rd_data(rd_data), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wren_p(wren_p), .wrds_p(wrds_p), .sto_p(sto_p), .rcl_p(rcl_p),
    .do_o(do_o), .do_oe(do_oe)
  );

  snv_ctl #(.STORE_CYCLES(STORE_CYCLES), .RECALL_CYCLES(RECALL_CYCLES)) u_ctl (
    .clk(clk), .rst_n(rst_n), .sto_p(sto_p), .rcl_p(rcl_p),
    .wren_p(wren_p), .wrds_p(wrds_p), .store_n(store_n), .recall_n(recall_n),
    .busy(busy), .wel(wel), .prl(prl),
    .copy_to_nv(copy_to_nv), .copy_to_ram(copy_to_ram)
  );

  snv_array u_arr (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .copy_to_nv(copy_to_nv),
    .copy_to_ram(copy_to_ram), .rd_data(rd_data)
  );
endmodule

// File: rtl/snv_chk.sv
module snv_port_chk (
  input logic clk,
  input logic rst_n,
  input logic ce,
  input logic busy,
  input logic do_oe
);
  p_oe_off_deselected_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> !do_oe);
  p_busy_silences_output_r12: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !do_oe);
endmodule

module snv_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic storing,
  input logic powerup,
  input logic wel,
  input logic prl
);
  p_store_guarded_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(storing) |-> (wel && prl));
  p_wel_cleared_after_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(storing) |-> !wel);
  p_powerup_no_prl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    powerup |-> !prl);
endmodule

bind snv_ram_slave snv_port_chk u_port_chk (
  .clk(clk), .rst_n(rst_n), .ce(ce), .busy(busy), .do_oe(do_oe)
);

bind snv_ctl snv_ctl_chk u_ctl_chk (
  .clk(clk), .rst_n(rst_n), .storing(mode == snv_pkg::M_STORE),
  .powerup(pu), .wel(wel), .prl(prl)
);

// File: tb/snv_ram_slave_tb.sv
module snv_ram_slave_tb_top;
  localparam int STC = 300;
  localparam int RCC = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce = 1'b0, sk = 1'b0, di = 1'b0;
  logic store_n = 1'b1, recall_n = 1'b1;
  logic do_o, do_oe, busy;
  int   errors = 0, checks = 0, busy_cnt = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  always @(posedge clk) if (busy) busy_cnt <= busy_cnt + 1;

  snv_ram_slave #(.STORE_CYCLES(STC), .RECALL_CYCLES(RCC)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce(ce), .sk(sk), .di(di),
    .store_n(store_n), .recall_n(recall_n),
    .do_o(do_o), .do_oe(do_oe), .busy(busy)
  );

  function automatic logic [15:0] seed(input logic [3:0] a);
    return {a, 4'hC, ~a, 4'h3};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic d);
    di = d; tick(2);
    sk = 1'b1; tick(2);
    sk = 1'b0; tick(2);
  endtask

  task automatic sel();
    @(negedge clk); ce = 1'b1; tick(2);
  endtask

  task automatic desel();
    ce = 1'b0; sk = 1'b0; tick(3);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
  endtask

  task automatic cmd(input logic [2:0] op);
    sel(); send_byte({5'b10000, op}); desel();
  endtask

  task automatic write_bits(input logic [3:0] a, input logic [31:0] d, input int n);
    sel(); send_byte({1'b1, a, 3'b011});
    for (int i = n - 1; i >= 0; i--) send_bit(d[i]);
    desel();
  endtask

  task automatic read_word(input logic [3:0] a, output logic [15:0] v, output logic oe);
    sel(); send_byte({1'b1, a, 3'b111});
    v[15] = do_o; oe = do_oe;
    for (int i = 14; i >= 0; i--) begin
      sk = 1'b1; tick(2);
      v[i] = do_o;
      sk = 1'b0; tick(2);
    end
    desel();
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 2000 && busy; k++) tick(1);
    tick(2);
  endtask

  task automatic expect_word(input string req, input logic [3:0] a, input logic [15:0] exp);
    logic [15:0] v; logic oe;
    read_word(a, v, oe);
    chk(req, {31'd0, oe}, 32'd1);
    chk(req, {16'd0, v}, {16'd0, exp});
  endtask

  // R11 R3: reset state, power-up recall ignores instructions
  task automatic t_powerup();
    chk("R3 do_oe at reset", {31'd0, do_oe}, 32'd0);
    tick(1);
    rst_n = 1'b1; tick(1);
    chk("R11 busy after reset", {31'd0, busy}, 32'd1);
    cmd(3'b100);          // write-enable sent while busy: ignored
    wait_idle();
    write_bits(4'd1, 32'h1111, 16);
    expect_word("R11 R7 powerup contents", 4'd1, seed(4'd1));
  endtask

  // R8: write without the latch is dropped
  task automatic t_no_wel();
    write_bits(4'd2, 32'h4242, 16);
    expect_word("R8 write without enable", 4'd2, seed(4'd2));
  endtask

  // R4 R2: enabled full write
  task automatic t_write();
    cmd(3'b100);
    write_bits(4'd3, 32'h1234, 16);
    expect_word("R4 R2 write then read", 4'd3, 16'h1234);
  endtask

  // R1: zeros before the start bit are ignored
  task automatic t_leading_zeros();
    sel();
    send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
    send_byte({1'b1, 4'd4, 3'b011});
    for (int i = 15; i >= 0; i--) send_bit(logic'(16'hCAFE >> i));
    desel();
    expect_word("R1 leading zeros", 4'd4, 16'hCAFE);
  endtask

  // R5 R6: short and long writes
  task automatic t_partial_overlong();
    write_bits(4'd6, 32'h16, 5);
    expect_word("R5 partial write", 4'd6, 16'h0016);
    write_bits(4'd7, 32'hABCDE, 20);
    expect_word("R6 overlong write", 4'd7, 16'hBCDE);
  endtask

  // R2 R9 R8: reserved op, guarded store, write-disable
  task automatic t_guards();
    busy_cnt = 0;
    cmd(3'b010);
    tick(4);
    chk("R2 reserved opcode no busy", busy_cnt, 0);
    busy_cnt = 0;
    cmd(3'b001);
    tick(4);
    chk("R9 store without prior recall", busy_cnt, 0);
    expect_word("R2 R9 data kept", 4'd3, 16'h1234);
    cmd(3'b000);
    write_bits(4'd3, 32'h9999, 16);
    expect_word("R8 write after disable", 4'd3, 16'h1234);
  endtask

  // R13: software recall restores the bank
  task automatic t_sw_recall();
    busy_cnt = 0;
    cmd(3'b101);
    wait_idle();
    chk("R13 recall busy length", busy_cnt, RCC);
    expect_word("R13 recall restores", 4'd3, seed(4'd3));
    expect_word("R13 recall restores second", 4'd4, seed(4'd4));
  endtask

  // R12 R8: store length, blocking, latch clear
  task automatic t_store();
    logic [15:0] v; logic oe;
    cmd(3'b100);
    write_bits(4'd3, 32'hBEEF, 16);
    busy_cnt = 0;
    cmd(3'b001);
    read_word(4'd5, v, oe);
    chk("R12 read blocked during store", {31'd0, oe}, 32'd0);
    wait_idle();
    chk("R12 store busy length", busy_cnt, STC);
    write_bits(4'd3, 32'h0001, 16);
    expect_word("R8 latch cleared by store", 4'd3, 16'hBEEF);
  endtask

  // R10 R12: pin recall brings back stored word
  task automatic t_hw_recall();
    cmd(3'b100);
    write_bits(4'd3, 32'h7777, 16);
    expect_word("R4 overwrite before recall", 4'd3, 16'h7777);
    busy_cnt = 0;
    @(negedge clk); recall_n = 1'b0; tick(3); recall_n = 1'b1;
    wait_idle();
    chk("R10 pin recall length", busy_cnt, RCC);
    expect_word("R10 R12 stored word recalled", 4'd3, 16'hBEEF);
  endtask

  // R10: pin store
  task automatic t_hw_store();
    cmd(3'b100);
    write_bits(4'd9, 32'h5A5A, 16);
    busy_cnt = 0;
    @(negedge clk); store_n = 1'b0; tick(3); store_n = 1'b1;
    wait_idle();
    chk("R10 pin store length", busy_cnt, STC);
    cmd(3'b100);
    write_bits(4'd9, 32'h0000, 16);
    cmd(3'b101);
    wait_idle();
    expect_word("R10 pin store persisted", 4'd9, 16'h5A5A);
  endtask

  // R3: dropping chip-enable mid-read releases the output
  task automatic t_ce_abort();
    sel(); send_byte({1'b1, 4'd9, 3'b110});
    chk("R3 oe during read", {31'd0, do_oe}, 32'd1);
    chk("R7 first bit", {31'd0, do_o}, 32'd0);
    desel();
    chk("R3 oe after ce low", {31'd0, do_oe}, 32'd0);
  endtask

  initial begin
    t_powerup();
    t_no_wel();
    t_write();
    t_leading_zeros();
    t_partial_overlong();
    t_guards();
    t_sw_recall();
    t_store();
    t_hw_recall();
    t_hw_store();
    t_ce_abort();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule